// File: doc/BRIEF.md
# Entropy Collector Control Peripheral

This block is a memory-mapped collector that turns a raw, externally generated entropy bit stream into words that software can read. Software picks an oscillator speed and an output length, turns the collector on and sets a start bit. The block then samples the raw entropy input once every programmed number of clock cycles. It packs the samples into a bank of eight 32-bit words, and when the requested number of bits has been gathered it drops the start bit. Software learns that a collection is complete by polling until start reads 0.

The register interface is 32 bits wide with a byte address, a single-cycle write strobe and a combinational read path. Writes to the control register carry a per-bit write-enable mask in the upper half of the data word, so a field can be changed without a read-modify-write. The oscillator itself lives outside the block; the block drives its run and speed-select pins.

Top module: `entropy_collector`

## Requirements
- R1: The control register is at byte offset 0x400 and reads as {16'h0, control[15:0]}. The sample-period register is at 0x404. Data word i (0..7) is at 0x410 + 4*i. After reset, control is 0, sample period is 1000 and all data words are 0.
- R2: A write to 0x400 changes only those control bits [15:0] whose mask bit in data[31:16] is 1. Every other control bit keeps its value.
- R3: Control bit 0 is START and bit 1 is ENABLE, and ENABLE drives `oscEnable`. Bits [3:2] drive `oscSpeed`. Bits [5:4] choose the length: 0 gives 64 bits, 1 gives 128, 2 gives 192 and 3 gives 256.
- R4: A write that sets START while ENABLE is 1 begins a collection. With period P and length L, bit k (0 <= k < L) takes the value of `entropyBit` at the (k+1)*P-th rising edge after the write edge. It is stored in word k/32 at bit k%32. START reads 1 until edge L*P, where it clears.
- R5: Data words at or beyond the selected length keep their previous contents during a collection.
- R6: A sample period of 0 behaves as 1, so one bit is taken on every clock edge.
- R7: If START is 1 while ENABLE is 0, no bit is stored and START clears on the next clock edge.
- R8: Setting START again during a collection restarts both the bit count and the sample count from zero.
- R9: Writing 32'hFFFF_0000 to the control register clears ENABLE and START at once, and no further bits are stored.
- R10: Reads from unmapped or unaligned offsets (including 0x004) return 0. Writes to them, and writes to the data words, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe, sampled on the rising edge |
| regAddr | input | 12 | Byte address for reads and writes |
| regWdata | input | 32 | Write data; for control writes, [31:16] is the bit mask |
| regRdata | output | 32 | Combinational read data for regAddr |
| entropyBit | input | 1 | Raw entropy bit from the external oscillator |
| oscEnable | output | 1 | Oscillator run request (control ENABLE) |
| oscSpeed | output | 2 | Oscillator speed select (control bits [3:2]) |

## Verification
The assertions assume that software does not change the length field while START is 1. A shorter length in mid-run could leave the bit index past the end of the new length. The assertions also expect `regAddr` and `regWdata` to be known whenever `regWrEn` is high. Every bench task writes length and enable while the collector is idle and only then sets START. Writes happen only at the falling edge, with all bus fields driven together. The restart and stop scenarios interrupt a running collection only through START or a full-mask stop write.

// File: rtl/ec_pkg.sv
package ec_pkg;
  localparam int ADDR_W     = 12;
  localparam int WORD_W     = 32;
  localparam int NUM_WORDS  = 8;
  localparam int TOTAL_BITS = WORD_W * NUM_WORDS;
  localparam int IDX_W      = $clog2(TOTAL_BITS);
  localparam int CNT_W      = IDX_W + 1;
  localparam int WSEL_W     = $clog2(NUM_WORDS);
  localparam int LEN_SHIFT  = 6;  // length unit of 64 bits

  localparam logic [ADDR_W-1:0] OFS_CTL    = 12'h400;
  localparam logic [ADDR_W-1:0] OFS_PERIOD = 12'h404;
  localparam logic [ADDR_W-1:0] OFS_DATA   = 12'h410;

  // strobe from control to datapath: store entropy bit at bitIdx
  typedef struct packed {
    logic             capture;
    logic [IDX_W-1:0] bitIdx;
  } capStrobe_t;
endpackage

// File: rtl/ec_ctrl.sv
module ec_ctrl
  import ec_pkg::*;
#(
  parameter int PERIOD_W     = 32,
  parameter int RESET_PERIOD = 1000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrCtl,
  input  logic                wrPeriod,
  input  logic [31:0]         wdata,
  output logic [15:0]         ctlQ,
  output logic [PERIOD_W-1:0] periodQ,
  output capStrobe_t          stb
);
  logic [15:0]         ctlR;
  logic [PERIOD_W-1:0] periodR;
  logic [PERIOD_W-1:0] sampCnt;
  logic [CNT_W-1:0]    bitCnt;
  logic [15:0]         wrMask;
  logic                touchStart, restart, running, tick, lastBit;
  logic [PERIOD_W-1:0] effPeriod;
  logic [CNT_W-1:0]    lenBits;

  always_comb begin
    wrMask     = wdata[31:16];
    touchStart = wrCtl & wrMask[0];
    restart    = touchStart & wdata[0];
    running    = ctlR[0] & ctlR[1] & ~touchStart;
    effPeriod  = (periodR == '0) ? PERIOD_W'(1) : periodR;
    tick       = running && (sampCnt == effPeriod - PERIOD_W'(1));
    lenBits    = (CNT_W'(ctlR[5:4]) + CNT_W'(1)) << LEN_SHIFT;
    lastBit    = tick && (bitCnt >= lenBits - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlR    <= '0;
      periodR <= PERIOD_W'(RESET_PERIOD);
      sampCnt <= '0;
      bitCnt  <= '0;
    end else begin
      if (wrCtl) ctlR <= (ctlR & ~wrMask) | (wdata[15:0] & wrMask);
      // self-clearing start: on completion, or when the collector is off
      if (!touchStart && ctlR[0] && (!ctlR[1] || lastBit)) ctlR[0] <= 1'b0;
      if (wrPeriod) periodR <= wdata[PERIOD_W-1:0];
      if (restart) begin
        sampCnt <= '0;
        bitCnt  <= '0;
      end else if (running) begin
        if (tick) begin
          sampCnt <= '0;
          bitCnt  <= bitCnt + CNT_W'(1);
        end else begin
          sampCnt <= sampCnt + PERIOD_W'(1);
        end
      end
    end
  end

  assign ctlQ       = ctlR;
  assign periodQ    = periodR;
  assign stb.capture = tick;
  assign stb.bitIdx  = bitCnt[IDX_W-1:0];
endmodule

// File: rtl/ec_datapath.sv
module ec_datapath
  import ec_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  capStrobe_t            stb,
  input  logic                  entropyBit,
  output logic [TOTAL_BITS-1:0] wordsFlat
);
  localparam int BSEL_W = $clog2(WORD_W);

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] wordR;
    logic              hit;
    assign hit = stb.capture && (stb.bitIdx[IDX_W-1:BSEL_W] == WSEL_W'(w));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    wordR <= '0;
      else if (hit) wordR[stb.bitIdx[BSEL_W-1:0]] <= entropyBit;
    end
    assign wordsFlat[w*WORD_W +: WORD_W] = wordR;
  end
endmodule

// File: rtl/entropy_collector.sv
module entropy_collector
  import ec_pkg::*;
#(
  parameter int PERIOD_W     = 32,
  parameter int RESET_PERIOD = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              entropyBit,
  output logic              oscEnable,
  output logic [1:0]        oscSpeed
);
  logic [15:0]           ctlView;
  logic [PERIOD_W-1:0]   periodView;
  logic [TOTAL_BITS-1:0] wordsFlat;
  capStrobe_t            capStb;
  logic                  selCtl, selPeriod, selData;
  logic [ADDR_W-1:0]     dataOfs;
  logic [WSEL_W-1:0]     dataIdx;

  always_comb begin
    selCtl    = (regAddr == OFS_CTL);
    selPeriod = (regAddr == OFS_PERIOD);
    dataOfs   = regAddr - OFS_DATA;
    selData   = (regAddr[1:0] == 2'b00) && (regAddr >= OFS_DATA) &&
                (regAddr < OFS_DATA + ADDR_W'(4 * NUM_WORDS));
    dataIdx   = dataOfs[2 +: WSEL_W];
  end

  ec_ctrl #(.PERIOD_W(PERIOD_W), .RESET_PERIOD(RESET_PERIOD)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrCtl(regWrEn & selCtl), .wrPeriod(regWrEn & selPeriod),
    .wdata(regWdata), .ctlQ(ctlView), .periodQ(periodView), .stb(capStb)
  );

  ec_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(capStb),
    .entropyBit(entropyBit), .wordsFlat(wordsFlat)
  );

  always_comb begin
    regRdata = '0;
    if (selCtl)         regRdata = {16'h0, ctlView};
    else if (selPeriod) regRdata = 32'(periodView);
    else if (selData)   regRdata = wordsFlat[dataIdx*WORD_W +: WORD_W];
  end

  assign oscEnable = ctlView[1];
  assign oscSpeed  = ctlView[3:2];
endmodule

// File: rtl/ec_checker.sv
module ec_checker
  import ec_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWrEn,
  input logic [ADDR_W-1:0]     regAddr,
  input logic [31:0]           regWdata,
  input logic [15:0]           ctlView,
  input capStrobe_t            capStb,
  input logic [TOTAL_BITS-1:0] words
);
  logic wrCtl;
  assign wrCtl = regWrEn && (regAddr == OFS_CTL);

  // R2: unmasked bits hold across a control write (START excluded, hardware clears it)
  a_r2_masked_hold: assert property (@(posedge clk) disable iff (!rstN)
    wrCtl |=> (((ctlView ^ $past(ctlView)) & ~$past(regWdata[31:16])) & 16'hFFFE) == 16'h0);

  a_r9_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtl && regWdata == 32'hFFFF_0000) |=> (ctlView == 16'h0));

  a_r7_idle_start_drops: assert property (@(posedge clk) disable iff (!rstN)
    (ctlView[0] && !ctlView[1] && !(wrCtl && regWdata[16])) |=> !ctlView[0]);

  a_r4_capture_when_running: assert property (@(posedge clk) disable iff (!rstN)
    capStb.capture |-> (ctlView[0] && ctlView[1]));

  a_r4_start_from_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctlView[0]) |-> $past(wrCtl));

  a_r5_index_in_length: assert property (@(posedge clk) disable iff (!rstN)
    capStb.capture |-> ({1'b0, capStb.bitIdx} < ((CNT_W'(ctlView[5:4]) + CNT_W'(1)) << LEN_SHIFT)));

  a_r10_words_readonly: assert property (@(posedge clk) disable iff (!rstN)
    !capStb.capture |=> $stable(words));
endmodule

bind entropy_collector ec_checker u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWdata(regWdata), .ctlView(ctlView), .capStb(capStb), .words(wordsFlat)
);

// File: tb/test_entropy_collector.sv
module test_entropy_collector;
  localparam logic [11:0] CTL = 12'h400, PER = 12'h404, DAT = 12'h410;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        entropyBit = 1'b0;
  logic        oscEnable;
  logic [1:0]  oscSpeed;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] expW [8];

  always #10 clk = ~clk;  // 50 MHz

  entropy_collector i_entropy_collector (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .entropyBit(entropyBit),
    .oscEnable(oscEnable), .oscSpeed(oscSpeed)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; write lands on the next rising edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    regAddr = a; #1; v = regRdata;
  endtask

  function automatic logic ent(input int c, input int seed);
    logic [31:0] h;
    h = (c * 32'h9E3779B1) + (seed * 32'h85EBCA6B);
    return h[17] ^ h[29] ^ h[3];
  endfunction

  task automatic checkWords(input string tag);
    logic [31:0] v;
    for (int w = 0; w < 8; w++) begin
      rd(DAT + 12'(4 * w), v);
      chk(tag, v, expW[w]);
    end
  endtask

  // start a collection of n bits with effective period p, entropy pattern seed
  task automatic collect(input int n, input int p, input int seed, input string tag);
    logic [31:0] v;
    wr(CTL, 32'h0001_0001);
    for (int c = 1; c <= n * p; c++) begin
      entropyBit = ent(c, seed);
      if (c == n * p) begin
        rd(CTL, v);
        chk({tag, " start busy before last edge"}, 32'(v[0]), 32'd1);
      end
      @(negedge clk);
    end
    rd(CTL, v);
    chk({tag, " start cleared"}, 32'(v[0]), 32'd0);
    for (int k = 0; k < n; k++) expW[k / 32][k % 32] = ent((k + 1) * p, seed);
    checkWords(tag);
  endtask

  task automatic tReset;
    logic [31:0] v;
    rd(CTL, v); chk("R1 ctl reset", v, 32'h0);
    rd(PER, v); chk("R1 period reset", v, 32'd1000);
    rd(DAT, v); chk("R1 word0 reset", v, 32'h0);
    rd(DAT + 12'h1C, v); chk("R1 word7 reset", v, 32'h0);
    chk("R3 oscEnable reset", 32'(oscEnable), 32'd0);
  endtask

  task automatic tMask;
    logic [31:0] v;
    wr(CTL, 32'h003C_0034);  // length 3, speed 1
    rd(CTL, v); chk("R2 masked fields", v, 32'h34);
    chk("R3 oscSpeed", 32'(oscSpeed), 32'd1);
    chk("R3 oscEnable off", 32'(oscEnable), 32'd0);
    wr(CTL, 32'h0002_FFFF);  // only enable may change
    rd(CTL, v); chk("R2 enable only", v, 32'h36);
    chk("R3 oscEnable on", 32'(oscEnable), 32'd1);
    wr(CTL, 32'h0030_0000);  // length back to 64
    rd(CTL, v); chk("R2 length cleared", v, 32'h06);
  endtask

  task automatic tCollect64;
    wr(PER, 32'd1);
    collect(64, 1, 11, "R4/R5 len64 p1");
  endtask

  task automatic tCollect256;
    wr(CTL, 32'h0030_0030);
    collect(256, 1, 22, "R4 len256 p1");
  endtask

  task automatic tCollectSlow;
    wr(CTL, 32'h0030_0000);
    wr(PER, 32'd3);
    collect(64, 3, 33, "R5 len64 p3 upper words kept");
  endtask

  task automatic tPeriodZero;
    logic [31:0] v;
    wr(PER, 32'd0);
    rd(PER, v); chk("R6 period reads 0", v, 32'd0);
    wr(CTL, 32'h0030_0010);
    collect(128, 1, 44, "R6 period0 len128");
  endtask

  task automatic tNoEnable;
    logic [31:0] v;
    wr(CTL, 32'h0002_0000);
    chk("R7 oscEnable off", 32'(oscEnable), 32'd0);
    wr(CTL, 32'h0001_0001);
    entropyBit = ~entropyBit;
    rd(CTL, v); chk("R7 start seen", 32'(v[0]), 32'd1);
    @(negedge clk);
    entropyBit = ~entropyBit;
    rd(CTL, v); chk("R7 start dropped", 32'(v[0]), 32'd0);
    repeat (5) @(negedge clk);
    checkWords("R7 no bits stored");
  endtask

  task automatic tRestart;
    wr(PER, 32'd1);
    wr(CTL, 32'h0032_0012);  // enable, length 128
    wr(CTL, 32'h0001_0001);
    for (int c = 1; c <= 40; c++) begin
      entropyBit = ent(c, 55);
      @(negedge clk);
    end
    for (int k = 0; k < 40; k++) expW[k / 32][k % 32] = ent(k + 1, 55);
    collect(128, 1, 66, "R8 restart");
  endtask

  task automatic tStop;
    logic [31:0] v;
    wr(CTL, 32'h0030_0030);
    wr(CTL, 32'h0001_0001);
    for (int c = 1; c <= 10; c++) begin
      entropyBit = ent(c, 77);
      @(negedge clk);
    end
    for (int k = 0; k < 10; k++) expW[k / 32][k % 32] = ent(k + 1, 77);
    wr(CTL, 32'hFFFF_0000);
    rd(CTL, v); chk("R9 stop ctl", v, 32'h0);
    chk("R9 stop oscEnable", 32'(oscEnable), 32'd0);
    for (int c = 0; c < 20; c++) begin
      entropyBit = ~entropyBit;
      @(negedge clk);
    end
    checkWords("R9 no bits after stop");
  endtask

  task automatic tUnmapped;
    logic [31:0] v;
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, v); chk("R10 offset 0x004 reads 0", v, 32'h0);
    rd(12'h800, v); chk("R10 far offset reads 0", v, 32'h0);
    rd(12'h412, v); chk("R10 unaligned reads 0", v, 32'h0);
    rd(12'h430, v); chk("R10 past last word reads 0", v, 32'h0);
    wr(DAT, ~expW[0]);
    wr(DAT + 12'h1C, ~expW[7]);
    rd(CTL, v); chk("R10 ctl untouched", v, 32'h0);
    checkWords("R10 words read-only");
  endtask

  initial begin
    for (int w = 0; w < 8; w++) expW[w] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tMask();
    tCollect64();
    tCollect256();
    tCollectSlow();
    tPeriodZero();
    tNoEnable();
    tRestart();
    tStop();
    tUnmapped();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule